// File: doc/BRIEF.md
# Serial Word Bit-Clock Burst Generator

This block sits behind a demodulator that recovers an asynchronous serial line. The line carries 10-bit words: a low start bit, eight data bits, and a high stop bit. For every word the block drives a burst of exactly eight low-going clock pulses on `dclk_out`. Each pulse ends, with a rising edge, at the centre of one data bit, so an external shift register can clock the eight data bits straight off `data_out`. After the eighth pulse the block pulls the active-low `rdy_n` strobe low, which marks the word boundary for whatever latches the assembled byte.

The bit period is a fixed division of the reference clock (`DIV` cycles per bit, 2976 by default). The raw line first passes through a two-flop synchronizer. A high-to-low transition of the synchronized line, seen while `carrier_ok` is high, starts a word. Half a bit period later the line is sampled again, and the word goes ahead only if the line is still low. The copy of the line on `data_out` is forced high while the carrier qualifier is low. A synchronous active-high `rst`, which also serves as power-down, clears every counter and holds all three outputs high.

Top module: `word_clock_burst`

## Requirements
- R1: While `rst` is high at a rising clock edge, the edge clears all state, and `data_out`, `dclk_out` and `rdy_n` are all 1 after that edge.
- R2: After each edge, `data_out` equals 1 if `carrier_ok` was 0 at that edge. Otherwise it equals the `rx_in` value sampled two edges earlier (the two synchronizer stages).
- R3: A start is detected at edge E when the synchronized line was 1 before edge E-1, is 0 before edge E, and `carrier_ok` is 1 at E. This requires the block to be idle. While `carrier_ok` is 0, no start is detected and no pulse is produced.
- R4: At edge E+HALF (HALF = DIV/2) the synchronized line is sampled again. If it is 1, the word is abandoned: no pulses, and the block returns to idle.
- R5: A validated word produces exactly NBITS (8) low pulses on `dclk_out`. Pulse k (k = 0 first) belongs to the k-th data bit in transmission order, so the first pulse clocks the least significant bit.
- R6: Pulse k is low for exactly HALF cycles. `dclk_out` returns to 1 after edge E+HALF+(k+1)*DIV, which is the centre of data bit k as seen through the synchronizer.
- R7: `dclk_out` stays 1 at all other times, including the whole of the start and stop bits and idle.
- R8: `rdy_n` goes to 0 on the same edge as the last rising edge of `dclk_out` in a word. It stays 0 until the next detected start or until `carrier_ok` is 0.
- R9: If `carrier_ok` is 0 at an edge during a word, the word is abandoned: after that edge `dclk_out` and `rdy_n` are 1.
- R10: Consecutive rising edges of `dclk_out` within a word are exactly DIV cycles apart, with DIV a parameter (default 2976).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset / power-down |
| rx_in | input | 1 | Raw demodulated serial line, asynchronous |
| carrier_ok | input | 1 | Carrier qualifier, active high |
| data_out | output | 1 | Gated, synchronized copy of the line |
| dclk_out | output | 1 | Data clock, low-going pulses ending at bit centres |
| rdy_n | output | 1 | Word-complete strobe, active low |

## Verification
An input value sampled at edge n shows up on `data_out` after edge n+2. A start whose first low level is sampled at edge F is detected at edge F+2. Its k-th clock rise therefore follows edge F+2+HALF+(k+1)*DIV, and `rdy_n` falls on the same edge as the eighth rise. A drop of `carrier_ok` or a reset takes effect one edge after it is sampled. The reference model in the bench advances exactly once per rising edge, using the inputs that were applied for that edge. Outputs are compared at the following falling edge, so every expectation is checked in the very cycle it becomes due. Word-level checks then confirm the bit spacing, the first-rise position, the pulse count and the byte captured at each rise.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int unsigned BURST_DIV_DEFAULT  = 2976;
    localparam int unsigned BURST_BITS_DEFAULT = 8;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_VERIFY = 2'd1,
        SQ_SHIFT  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic level;
        logic fall;
    } line_t;

    // True in the second half of a bit period, the window in which the
    // clock pulse is held low.
    function automatic logic in_low_half(input int unsigned c, input int unsigned div);
        return c >= (div - div / 2);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output line_t line
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign line.level = s2_q;
    assign line.fall  = s3_q & ~s2_q;
endmodule

// File: rtl/data_gate.sv
module data_gate (
    input  logic clk,
    input  logic rst,
    input  logic carrier_ok,
    input  logic level,
    output logic data_out
);
    logic data_q;

    always_ff @(posedge clk) begin
        if (rst)             data_q <= 1'b1;
        else if (carrier_ok) data_q <= level;
        else                 data_q <= 1'b1;
    end

    assign data_out = data_q;
endmodule

// File: rtl/word_sequencer.sv
module word_sequencer
    import burst_pkg::*;
#(
    parameter int unsigned DIV   = BURST_DIV_DEFAULT,
    parameter int unsigned NBITS = BURST_BITS_DEFAULT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  carrier_ok,
    input  line_t line,
    output logic  dclk_out,
    output logic  rdy_n
);
    localparam int unsigned CW   = $clog2(DIV);
    localparam int unsigned IW   = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam int unsigned HALF = DIV / 2;
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);
    localparam logic [CW-1:0] DIV_M1  = CW'(DIV - 1);
    localparam logic [IW-1:0] LAST    = IW'(NBITS - 1);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic          rdy_q;

    always_ff @(posedge clk) begin
        if (rst || !carrier_ok) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            rdy_q   <= 1'b1;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (line.fall) begin
                        state_q <= SQ_VERIFY;
                        cnt_q   <= '0;
                        rdy_q   <= 1'b1;
                    end
                end
                SQ_VERIFY: begin
                    if (cnt_q == HALF_M1) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= line.level ? SQ_IDLE : SQ_SHIFT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_SHIFT: begin
                    if (cnt_q == DIV_M1) begin
                        cnt_q <= '0;
                        if (idx_q == LAST) begin
                            idx_q   <= '0;
                            state_q <= SQ_IDLE;
                            rdy_q   <= 1'b0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign dclk_out = !((state_q == SQ_SHIFT) && in_low_half(32'(cnt_q), DIV));
    assign rdy_n    = rdy_q;
endmodule

// File: rtl/word_clock_burst.sv
module word_clock_burst
    import burst_pkg::*;
#(
    parameter int unsigned DIV   = BURST_DIV_DEFAULT,
    parameter int unsigned NBITS = BURST_BITS_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    input  logic carrier_ok,
    output logic data_out,
    output logic dclk_out,
    output logic rdy_n
);
    line_t line;

    line_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .line (line)
    );

    data_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .carrier_ok (carrier_ok),
        .level      (line.level),
        .data_out   (data_out)
    );

    word_sequencer #(
        .DIV   (DIV),
        .NBITS (NBITS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .carrier_ok (carrier_ok),
        .line       (line),
        .dclk_out   (dclk_out),
        .rdy_n      (rdy_n)
    );
endmodule

// File: rtl/word_clock_burst_chk.sv
module word_clock_burst_chk #(
    parameter int unsigned DIV   = 2976,
    parameter int unsigned NBITS = 8
) (
    input logic clk,
    input logic rst,
    input logic rx_in,
    input logic carrier_ok,
    input logic data_out,
    input logic dclk_out,
    input logic rdy_n
);
    localparam int unsigned LW   = $clog2(DIV) + 1;
    localparam int unsigned HALF = DIV / 2;

    logic [LW-1:0] low_run;
    logic [7:0]    fall_cnt;
    logic          dclk_d, rdy_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            fall_cnt <= '0;
            dclk_d   <= 1'b1;
            rdy_d    <= 1'b1;
        end else begin
            dclk_d  <= dclk_out;
            rdy_d   <= rdy_n;
            low_run <= dclk_out ? '0 : low_run + 1'b1;
            if (!carrier_ok || (rdy_d && !rdy_n))
                fall_cnt <= '0;
            else if (dclk_d && !dclk_out)
                fall_cnt <= fall_cnt + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (data_out && dclk_out && rdy_n));

    p_gate_high_r2: assert property (@(posedge clk) disable iff (rst)
        !carrier_ok |=> data_out);

    p_pulse_count_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n) |-> (fall_cnt == 8'(NBITS)));

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(dclk_out) && $past(carrier_ok) && !$past(rst)) |-> (low_run == LW'(HALF)));

    p_ready_edge_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_n) |-> $rose(dclk_out));

    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        !carrier_ok |=> (dclk_out && rdy_n));

    always_comb begin
        if (!rst) begin
            a_ready_needs_idle_clk_r7: assert (rdy_n || dclk_out);
        end
    end
endmodule

bind word_clock_burst word_clock_burst_chk #(
    .DIV   (DIV),
    .NBITS (NBITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_in      (rx_in),
    .carrier_ok (carrier_ok),
    .data_out   (data_out),
    .dclk_out   (dclk_out),
    .rdy_n      (rdy_n)
);

// File: tb/tb_word_clock_burst.sv
module tb_word_clock_burst;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 48;
    localparam int NBITS = 8;
    localparam int HALF  = DIV / 2;

    logic clk = 1'b0;
    logic rst, rx_in, carrier_ok;
    logic data_out, dclk_out, rdy_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    word_clock_burst #(.DIV(DIV), .NBITS(NBITS)) dut (
        .clk(clk), .rst(rst), .rx_in(rx_in), .carrier_ok(carrier_ok),
        .data_out(data_out), .dclk_out(dclk_out), .rdy_n(rdy_n)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // behavioural reference state
    int hist[$];
    int m_mode = 0;   // 0 idle, 1 checking start, 2 clocking bits
    int m_age  = 0;
    int m_rdy  = 1;
    int m_data = 1;

    // word monitor
    int rises = 0;
    int last_rise = 0;
    int first_rise = 0;
    logic [7:0] shreg = 8'h00;
    bit word_done = 0;
    logic [7:0] word_val = 8'h00;
    int word_rises = 0;
    logic dclk_prev = 1'b1;
    logic rdy_prev = 1'b1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic model_edge(input bit rx, input bit cd, input bit r);
        int s2, s3;
        s2 = hist[hist.size()-2];
        s3 = hist[hist.size()-3];
        if (r) begin
            m_mode = 0; m_age = 0; m_rdy = 1; m_data = 1;
            hist.push_back(1); hist.push_back(1); hist.push_back(1);
        end else begin
            m_data = cd ? s2 : 1;
            if (!cd) begin
                m_mode = 0; m_age = 0; m_rdy = 1;
            end else if (m_mode == 0) begin
                if (s2 == 0 && s3 == 1) begin m_mode = 1; m_age = 0; m_rdy = 1; end
            end else if (m_mode == 1) begin
                m_age++;
                if (m_age == HALF) begin m_mode = (s2 == 0) ? 2 : 0; m_age = 0; end
            end else begin
                m_age++;
                if (m_age == NBITS * DIV) begin m_mode = 0; m_age = 0; m_rdy = 0; end
            end
            hist.push_back(rx);
        end
        while (hist.size() > 8) void'(hist.pop_front());
    endtask

    task automatic step(input bit rx, input bit cd, input bit r);
        int exp_dclk;
        rx_in = rx; carrier_ok = cd; rst = r;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        model_edge(rx, cd, r);
        exp_dclk = (m_mode == 2 && (m_age % DIV) >= DIV - HALF) ? 0 : 1;
        if (r) begin
            check(data_out === 1'b1 && dclk_out === 1'b1 && rdy_n === 1'b1, "R1",
                  "reset outputs", {data_out, dclk_out, rdy_n}, 7);
        end else begin
            check(data_out === 1'(m_data), "R2", "data_out", data_out, m_data);
            check(dclk_out === 1'(exp_dclk), "R6 R7", "dclk_out", dclk_out, exp_dclk);
            check(rdy_n === 1'(m_rdy), "R8", "rdy_n", rdy_n, m_rdy);
        end
        // word monitor
        if (r || !cd) begin
            rises = 0;
        end else begin
            if (!dclk_prev && dclk_out) begin
                rises++;
                shreg = {data_out, shreg[7:1]};
                if (rises == 1) first_rise = cyc;
                else check(cyc - last_rise == DIV, "R10", "rise spacing", cyc - last_rise, DIV);
                last_rise = cyc;
            end
            if (rdy_prev && !rdy_n) begin
                word_done = 1; word_val = shreg; word_rises = rises; rises = 0;
            end
        end
        dclk_prev = dclk_out;
        rdy_prev = rdy_n;
    endtask

    task automatic hold(input bit rx, input bit cd, input int n);
        for (int i = 0; i < n; i++) step(rx, cd, 1'b0);
    endtask

    task automatic send_word(input logic [7:0] b, input bit cd, input int gap, input bit expect_ok);
        int f;
        word_done = 0;
        step(1'b0, cd, 1'b0);
        f = cyc;
        hold(1'b0, cd, DIV - 1);
        if (cd) check(rdy_n === 1'b1, "R8", "rdy_n back high after start", rdy_n, 1);
        for (int k = 0; k < NBITS; k++) hold(b[k], cd, DIV);
        hold(1'b1, cd, DIV + gap);
        if (expect_ok) begin
            check(word_done, "R5", "word completed", word_done, 1);
            check(word_rises == NBITS, "R5", "pulse count", word_rises, NBITS);
            check(word_val == b, "R5", "captured byte", word_val, b);
            check(first_rise == f + 2 + HALF + DIV, "R6", "first rise cycle", first_rise, f + 2 + HALF + DIV);
            check(rdy_n === 1'b0, "R8", "rdy_n low after word", rdy_n, 0);
        end else begin
            check(!word_done, "R3", "no word without carrier", word_done, 0);
            check(rises == 0, "R3", "no pulses without carrier", rises, 0);
        end
    endtask

    initial begin
        rst = 1'b1; rx_in = 1'b1; carrier_ok = 1'b0;
        hist.push_back(1); hist.push_back(1); hist.push_back(1);
        @(negedge clk);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1);
        hold(1'b1, 1'b1, 20);

        send_word(8'hA5, 1'b1, 6, 1'b1);
        send_word(8'h00, 1'b1, 0, 1'b1);
        send_word(8'hFF, 1'b1, 3, 1'b1);
        send_word(8'h3C, 1'b1, 10, 1'b1);

        // short glitch rejected at the mid-start check
        rises = 0; word_done = 0;
        hold(1'b0, 1'b1, DIV / 4);
        hold(1'b1, 1'b1, 3 * DIV);
        check(rises == 0, "R4", "glitch pulses", rises, 0);
        check(!word_done, "R4", "glitch word", word_done, 0);
        check(dclk_out === 1'b1, "R4", "dclk idle after glitch", dclk_out, 1);

        // carrier absent: line activity ignored
        send_word(8'h5A, 1'b0, 4, 1'b0);
        hold(1'b1, 1'b1, 10);

        // carrier drop mid-word
        step(1'b0, 1'b1, 1'b0);
        hold(1'b0, 1'b1, DIV - 1);
        hold(1'b1, 1'b1, 2 * DIV + HALF + 5);
        step(1'b1, 1'b0, 1'b0);
        check(dclk_out === 1'b1 && rdy_n === 1'b1, "R9", "abort outputs", {dclk_out, rdy_n}, 3);
        hold(1'b1, 1'b0, 2 * DIV);
        hold(1'b1, 1'b1, 10);
        send_word(8'h96, 1'b1, 5, 1'b1);

        // reset in the middle of a word
        step(1'b0, 1'b1, 1'b0);
        hold(1'b0, 1'b1, DIV - 1);
        hold(1'b0, 1'b1, DIV + HALF + 2);
        step(1'b0, 1'b1, 1'b1);
        check(dclk_out === 1'b1 && rdy_n === 1'b1 && data_out === 1'b1, "R1", "mid-word reset",
              {data_out, dclk_out, rdy_n}, 7);
        hold(1'b1, 1'b1, 12 * DIV);
        send_word(8'h01, 1'b1, 5, 1'b1);
        send_word(8'h80, 1'b1, 5, 1'b1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule